// File: doc/BRIEF.md
# Timer Compare/Capture Channel

This block is one general-purpose register channel of a 16-bit timer. It keeps a 4-bit control field and a compare/capture register. The counter is free-running and sits outside the block, which watches its value on an input bus.

The control field selects the channel's role:
- In compare mode, the channel drives one of two timer pins (A or C). When the counter equals the register, the selected pin is driven low, driven high, toggled or left alone.
- In capture mode, the channel watches pin C through a two-stage synchronizer. On the chosen edge, it latches the counter into the register and raises a one-cycle capture flag.

Software-side logic writes the control field and the register through plain write strobes. The block has no bus protocol of its own.

Top module: `tmr_gr_channel`

## Requirements
- R1: After reset the control field reads 4'b1000, the register reads 0, both pin outputs are 0 and the capture flag is 0.
- R2: Control bits [3:2] pick the role. 2'b00 is compare on pin A and 2'b10 is compare on pin C; the pin that is not selected keeps its value.
- R3: In compare mode, bits [1:0] give the match action: 2'b00 no change, 2'b01 drive 0, 2'b10 drive 1, 2'b11 toggle.
- R4: A match is a cycle in which `cnt_in` equals the register. The pin takes its new value at the clock edge that ends that cycle. Without a match, the pins do not change.
- R5: With bits [3:2] = 2'b11, bits [1:0] select the capture edge on pin C: 2'b00 rising only, 2'b01 falling only, 2'b1x both.
- R6: A pin C transition reaches the edge detector after two synchronizer stages. On the third rising clock edge after the pin changes, the register loads the `cnt_in` value of the preceding cycle, and the capture flag is high for exactly that one cycle.
- R7: While the channel is in capture mode, both pin outputs hold their values, even when the counter equals the register.
- R8: Bits [3:2] = 2'b01 is a disabled setting: pin C edges cause no capture, and counter matches change no pin.
- R9: In compare mode, edges on pin C cause no capture and leave the register unchanged.
- R10: A write strobe on `ctrl_wr` or `gr_wr` loads the written value at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_wr | input | 1 | Control field write strobe |
| ctrl_wdata | input | 4 | Control field write value |
| gr_wr | input | 1 | Register write strobe |
| gr_wdata | input | CNT_W | Register write value |
| cnt_in | input | CNT_W | Free-running counter value |
| pin_c_in | input | 1 | Asynchronous pin C input for capture |
| ctrl_q_out | output | 4 | Current control field |
| gr_value | output | CNT_W | Current register value |
| cap_flag | output | 1 | One-cycle capture pulse |
| pin_a_out | output | 1 | Pin A output |
| pin_c_out | output | 1 | Pin C output |

## Verification
The assertions check four things on every cycle:
- The pin responds correctly to each match action.
- No pin moves without an enabled match.
- Pins hold while the channel is in capture mode.
- A raised capture flag always comes with the previous counter value in the register.

They also check that the decoded roles never overlap and that the disabled setting never raises the flag. Only the bench scenarios can show the exact three-edge capture latency, the edge selection for each capture code, and the ignored pin edges in compare and disabled modes. The same holds for the cumulative pin states across a sequence of compare codes.

// File: rtl/tmr_gr_pkg.sv
package tmr_gr_pkg;

    typedef enum logic [1:0] {
        ACT_NONE   = 2'b00,
        ACT_LOW    = 2'b01,
        ACT_HIGH   = 2'b10,
        ACT_TOGGLE = 2'b11
    } act_e;

    localparam int NUM_PINS = 2;
    localparam int PIN_A    = 0;
    localparam int PIN_C    = 1;

    localparam logic [3:0] CTRL_RESET = 4'b1000;

    typedef struct packed {
        logic cmp_a;
        logic cmp_c;
        logic cap_en;
        logic cap_rise;
        logic cap_fall;
        act_e act;
    } mode_t;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sync_o,
    output logic prev_o
);
    localparam int LAST = STAGES;

    logic [LAST:0] sh_d, sh_q;

    always_comb begin
        sh_d[0] = din;
        for (int k = 1; k <= LAST; k++) begin
            sh_d[k] = sh_q[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign sync_o = sh_q[LAST-1];
    assign prev_o = sh_q[LAST];
endmodule

// File: rtl/tmr_mode_decode.sv
module tmr_mode_decode
    import tmr_gr_pkg::*;
(
    input  logic [3:0] ctrl,
    output mode_t      mode
);
    always_comb begin
        mode          = '0;
        mode.act      = act_e'(ctrl[1:0]);
        mode.cmp_a    = (ctrl[3:2] == 2'b00);
        mode.cmp_c    = (ctrl[3:2] == 2'b10);
        mode.cap_en   = (ctrl[3:2] == 2'b11);
        mode.cap_rise = mode.cap_en && (ctrl[1] || !ctrl[0]);
        mode.cap_fall = mode.cap_en && (ctrl[1] ||  ctrl[0]);
    end
endmodule

// File: rtl/tmr_pin_action.sv
module tmr_pin_action
    import tmr_gr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic match,
    input  act_e act,
    output logic pin_o
);
    logic pin_d, pin_q;

    always_comb begin
        pin_d = pin_q;
        if (en && match) begin
            case (act)
                ACT_LOW:    pin_d = 1'b0;
                ACT_HIGH:   pin_d = 1'b1;
                ACT_TOGGLE: pin_d = !pin_q;
                default:    pin_d = pin_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin_d;
    end

    assign pin_o = pin_q;

    assert_drive_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && match && act == ACT_HIGH) |=> pin_o);
    assert_drive_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && match && act == ACT_LOW) |=> !pin_o);
    assert_toggle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (en && match && act == ACT_TOGGLE) |=> (pin_o != $past(pin_o)));
    assert_hold_no_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && match) |=> $stable(pin_o));
endmodule

// File: rtl/tmr_gr_channel.sv
module tmr_gr_channel
    import tmr_gr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [3:0]       ctrl_wdata,
    input  logic             gr_wr,
    input  logic [CNT_W-1:0] gr_wdata,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             pin_c_in,
    output logic [3:0]       ctrl_q_out,
    output logic [CNT_W-1:0] gr_value,
    output logic             cap_flag,
    output logic             pin_a_out,
    output logic             pin_c_out
);
    typedef struct packed {
        logic [3:0]       ctrl;
        logic [CNT_W-1:0] gr;
        logic             flag;
    } regs_t;

    regs_t st_d, st_q;
    mode_t mode;
    logic  pc_sync, pc_prev, edge_hit, match;
    logic [NUM_PINS-1:0] pin_en, pin_q;

    tmr_mode_decode u_decode (
        .ctrl (st_q.ctrl),
        .mode (mode)
    );

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .din    (pin_c_in),
        .sync_o (pc_sync),
        .prev_o (pc_prev)
    );

    assign match    = (cnt_in == st_q.gr);
    assign edge_hit = (mode.cap_rise && pc_sync && !pc_prev) ||
                      (mode.cap_fall && !pc_sync && pc_prev);

    always_comb begin
        st_d      = st_q;
        st_d.flag = 1'b0;
        if (ctrl_wr) st_d.ctrl = ctrl_wdata;
        if (gr_wr) begin
            st_d.gr = gr_wdata;
        end else if (edge_hit) begin
            st_d.gr   = cnt_in;
            st_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ctrl <= CTRL_RESET;
            st_q.gr   <= '0;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pin_en[PIN_A] = mode.cmp_a;
    assign pin_en[PIN_C] = mode.cmp_c;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        tmr_pin_action u_act (
            .clk   (clk),
            .rst_n (rst_n),
            .en    (pin_en[p]),
            .match (match),
            .act   (mode.act),
            .pin_o (pin_q[p])
        );
    end

    assign ctrl_q_out = st_q.ctrl;
    assign gr_value   = st_q.gr;
    assign cap_flag   = st_q.flag;
    assign pin_a_out  = pin_q[PIN_A];
    assign pin_c_out  = pin_q[PIN_C];

    assert_roles_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode.cmp_a, mode.cmp_c, mode.cap_en}));
    assert_flag_loads_counter_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cap_flag |-> (gr_value == $past(cnt_in)));
    assert_pins_hold_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q_out[3:2] == 2'b11) |=> ($stable(pin_a_out) && $stable(pin_c_out)));
    assert_disabled_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q_out[3:2] == 2'b01) |=> !cap_flag);
endmodule

// File: tb/tmr_gr_channel_tb.sv
module tmr_gr_channel_tb;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 1'b0;
    logic [3:0] ctrl_wdata = '0;
    logic gr_wr = 1'b0;
    logic [W-1:0] gr_wdata = '0;
    logic [W-1:0] cnt_in = '0;
    logic pin_c_in = 1'b0;
    logic [3:0] ctrl_q_out;
    logic [W-1:0] gr_value;
    logic cap_flag, pin_a_out, pin_c_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = !clk;

    tmr_gr_channel #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .gr_wr(gr_wr), .gr_wdata(gr_wdata), .cnt_in(cnt_in), .pin_c_in(pin_c_in),
        .ctrl_q_out(ctrl_q_out), .gr_value(gr_value), .cap_flag(cap_flag),
        .pin_a_out(pin_a_out), .pin_c_out(pin_c_out)
    );

    // {ctrl[3:0], expected pin A, expected pin C}, cumulative from reset
    localparam logic [5:0] VEC [9] = '{
        {4'b0010, 1'b1, 1'b0},
        {4'b1010, 1'b1, 1'b1},
        {4'b0001, 1'b0, 1'b1},
        {4'b1011, 1'b0, 1'b0},
        {4'b0011, 1'b1, 1'b0},
        {4'b0000, 1'b1, 1'b0},
        {4'b1000, 1'b1, 1'b0},
        {4'b0110, 1'b1, 1'b0},
        {4'b1110, 1'b1, 1'b0}
    };

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [3:0] v);
        @(negedge clk); ctrl_wr = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_wr = 1'b0;
    endtask

    task automatic cap_edge(logic val, bit exp_cap, logic [W-1:0] cnt, string req);
        logic [W-1:0] old;
        @(negedge clk);
        cnt_in = cnt; pin_c_in = val; old = gr_value;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check({req, " flag"}, cap_flag, exp_cap);
        check({req, " gr"}, gr_value, exp_cap ? cnt : old);
        @(negedge clk);
        check({req, " flag one cycle"}, cap_flag, 1'b0);
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        check("R1 ctrl", ctrl_q_out, 4'b1000);
        check("R1 gr", gr_value, 0);
        check("R1 pins", {pin_a_out, pin_c_out}, 2'b00);
        check("R1 flag", cap_flag, 0);

        // R2 R3 R4 R10: compare vector walk
        foreach (VEC[i]) begin
            @(negedge clk);
            ctrl_wr = 1'b1; ctrl_wdata = VEC[i][5:2];
            gr_wr = 1'b1; gr_wdata = 16'h1234; cnt_in = 16'h0000;
            @(negedge clk);
            ctrl_wr = 1'b0; gr_wr = 1'b0;
            check("R10 ctrl write", ctrl_q_out, VEC[i][5:2]);
            check("R10 gr write", gr_value, 16'h1234);
            cnt_in = 16'h1234;
            @(negedge clk);
            cnt_in = 16'h0000;
            check($sformatf("R3 R2 R7 vec%0d pins", i), {pin_a_out, pin_c_out}, VEC[i][1:0]);
        end

        // R5 R6: capture edge selection
        wr_ctrl(4'b1100);
        cap_edge(1'b1, 1'b1, 16'h0AAA, "R5 R6 rise on rise-code");
        cap_edge(1'b0, 1'b0, 16'h0BBB, "R5 fall on rise-code");
        wr_ctrl(4'b1101);
        cap_edge(1'b1, 1'b0, 16'h0CCC, "R5 rise on fall-code");
        cap_edge(1'b0, 1'b1, 16'h0CCC, "R5 R6 fall on fall-code");
        wr_ctrl(4'b1110);
        cap_edge(1'b1, 1'b1, 16'h0111, "R5 both-code rise");
        cap_edge(1'b0, 1'b1, 16'h0222, "R5 both-code fall");
        wr_ctrl(4'b1111);
        cap_edge(1'b1, 1'b1, 16'h0333, "R5 code 11 rise");

        // R7: pins hold in capture mode while the counter matches
        @(negedge clk); cnt_in = 16'h0333;
        @(negedge clk); cnt_in = 16'h0000;
        check("R7 pins hold", {pin_a_out, pin_c_out}, 2'b10);

        // R8: disabled setting
        wr_ctrl(4'b0110);
        cap_edge(1'b0, 1'b0, 16'h0444, "R8 disabled edge");
        @(negedge clk); cnt_in = 16'h0333;
        @(negedge clk); cnt_in = 16'h0000;
        check("R8 disabled pins", {pin_a_out, pin_c_out}, 2'b10);

        // R9: compare mode ignores pin edges
        wr_ctrl(4'b1000);
        cap_edge(1'b1, 1'b0, 16'h0555, "R9 compare-mode edge");

        // R4: no match, no change
        wr_ctrl(4'b0011);
        @(negedge clk); gr_wr = 1'b1; gr_wdata = 16'h5555; cnt_in = 16'h5554;
        @(negedge clk); gr_wr = 1'b0;
        repeat (4) @(negedge clk);
        check("R4 no match hold", {pin_a_out, pin_c_out}, 2'b10);
        cnt_in = 16'h5555;
        @(negedge clk); cnt_in = 16'h0000;
        check("R4 match toggles A", {pin_a_out, pin_c_out}, 2'b00);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule